// File: doc/BRIEF.md
# Tiny 8-bit Single-Cycle Processor

A minimal processor core that commits one instruction on every clock edge. Its architectural state is four 8-bit general registers (r0 to r3), a 6-bit program counter and a 64-byte data memory. A separate 64-entry instruction store of 16-bit words is indexed by the PC. The instruction set has five operations: register add, byte load, byte store, branch-if-equal and absolute jump.

The core is built so that each instruction can be checked as one before/after transformation of the architectural state. A hold input freezes execution. While it is held, a debug port preloads the instruction store and the data memory. Observation ports expose the PC, all four registers, and any data-memory byte selected by an address, so a bench can compare the complete state after every commit.

Top module: `tiny_cpu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC and all four registers become 0 at that edge. Reset leaves the contents of the instruction store and the data memory unchanged.
- R2: While `dbg_hold` is 1, no instruction commits, so the PC and the registers stay unchanged. While `dbg_hold` is 1, `dbg_iwe` writes `dbg_idata` into the instruction store at `dbg_addr`, and `dbg_dwe` writes `dbg_ddata` into the data memory at `dbg_addr`. While `dbg_hold` is 0, both debug write enables are ignored.
- R3: The instruction word is laid out as follows: bits [15:13] hold the opcode (add=0, lw=1, sw=2, beq=3, j=4), bits [12:11] hold field A, bits [10:9] hold field B, bits [8:7] hold field C, bit 6 is ignored, and bits [5:0] hold a signed immediate or a jump target.
- R4: add writes reg[B] + reg[C] modulo 256 into reg[A], and the PC advances by 1. Both source values are the values from before the commit, even when A equals a source field.
- R5: lw loads mem[(reg[B][5:0] + imm) mod 64] into reg[A], and the PC advances by 1.
- R6: sw writes reg[A] into mem[(reg[B][5:0] + imm) mod 64], leaves all registers unchanged, and advances the PC by 1.
- R7: beq compares reg[A] with reg[B]. When they are equal, the PC becomes (PC + 1 + sign-extended imm) mod 64. When they differ, the PC becomes PC + 1.
- R8: j loads the PC with the 6-bit target held in bits [5:0].
- R9: Opcodes 5, 6 and 7 change nothing except advancing the PC by 1.
- R10: `obs_regs` packs r3, r2, r1 and r0 into bits [31:24], [23:16], [15:8] and [7:0] respectively. `obs_mem_data` shows mem[`obs_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of PC and registers |
| dbg_hold | input | 1 | Freezes execution and enables the debug writes |
| dbg_iwe | input | 1 | Instruction-store write enable (takes effect only while held) |
| dbg_dwe | input | 1 | Data-memory write enable (takes effect only while held) |
| dbg_addr | input | 6 | Address for the debug writes |
| dbg_idata | input | 16 | Instruction word to preload |
| dbg_ddata | input | 8 | Data byte to preload |
| obs_addr | input | 6 | Data-memory address to observe |
| obs_pc | output | 6 | Current program counter |
| obs_regs | output | 32 | Packed registers {r3,r2,r1,r0} |
| obs_mem_data | output | 8 | Data-memory byte at obs_addr |

## Verification
In a single commit, the register file can be read and written at the same index. For example, `add r1,r1,r1` and `lw r0,-1(r0)` each use as a source the register they overwrite. This is provoked by placing both instructions in the program. They are judged correct when the result is computed from the pre-commit value: 250+250 gives 244 after wrapping, and a base of 0 with imm -1 gives address 63. A store followed at once by a load of the same byte, and a taken branch whose target wraps past address 63, are also provoked in the same program run.

// File: rtl/tcpu_pkg.sv
// Package: shared constants and the instruction word layout for tiny_cpu.
// Assumes the fixed 16-bit encoding: 3-bit opcode, three 2-bit fields, spare bit, 6-bit immediate.
package tcpu_pkg;
    localparam int XLEN_D  = 8;
    localparam int ALEN_D  = 6;
    localparam int NREG_D  = 4;
    localparam int IWORD   = 16;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_LW  = 3'd1;
    localparam logic [2:0] OP_SW  = 3'd2;
    localparam logic [2:0] OP_BEQ = 3'd3;
    localparam logic [2:0] OP_JMP = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [1:0] fa;
        logic [1:0] fb;
        logic [1:0] fc;
        logic       spare;
        logic [5:0] imm;
    } insn_t;
endpackage

// File: rtl/tcpu_regfile.sv
// Module: register file with two combinational read ports and one synchronous write port.
// Assumes the sync active-low reset clears every register; reads return pre-write values.
module tcpu_regfile #(
    parameter int W = 8,
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [IW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    output logic [N*W-1:0] regs_flat
);
    logic [W-1:0] rf [N];

    // Write port and reset of all registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rf[i] <= '0;
        end else if (we) begin
            rf[wa] <= wd;
        end
    end

    // Read ports see the state before this cycle's write.
    assign rd_a = rf[ra_a];
    assign rd_b = rf[ra_b];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flat
            assign regs_flat[g*W +: W] = rf[g];
        end
    endgenerate

    // A register write lands at the named index (R4, R5).
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rf[$past(wa)] == $past(wd));
endmodule

// File: rtl/tcpu_dmem.sv
// Module: data memory, one synchronous write port and two combinational read ports.
// Assumes no reset: contents survive reset and are preloaded through the write port.
module tcpu_dmem #(
    parameter int W = 8,
    parameter int A = 6,
    localparam int DEPTH = 1 << A
) (
    input  logic         clk,
    input  logic         we,
    input  logic [A-1:0] wa,
    input  logic [W-1:0] wd,
    input  logic [A-1:0] ra_x,
    output logic [W-1:0] rd_x,
    input  logic [A-1:0] ra_o,
    output logic [W-1:0] rd_o
);
    logic [W-1:0] mem [DEPTH];

    // Single write port shared by store instructions and debug preload.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd_x = mem[ra_x];
    assign rd_o = mem[ra_o];

    // A written byte is readable at its address on the next cycle (R6).
    assert_store_lands_R6: assert property (@(posedge clk)
        we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/tcpu_imem.sv
// Module: instruction store indexed by the PC, written only through the debug port.
// Assumes the caller gates the write enable with the hold condition.
module tcpu_imem #(
    parameter int IW = 16,
    parameter int A  = 6,
    localparam int DEPTH = 1 << A
) (
    input  logic          clk,
    input  logic          we,
    input  logic [A-1:0]  wa,
    input  logic [IW-1:0] wd,
    input  logic [A-1:0]  ra,
    output logic [IW-1:0] rd
);
    logic [IW-1:0] mem [DEPTH];

    // Preload write port.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    assign rd = mem[ra];
endmodule

// File: rtl/tiny_cpu.sv
// Module: single-cycle core; decodes the word at PC, executes and commits it on each edge.
// Assumes ALEN matches the 6-bit immediate and NREG the 2-bit register fields of the encoding.
module tiny_cpu
    import tcpu_pkg::*;
#(
    parameter int XLEN = XLEN_D,
    parameter int ALEN = ALEN_D,
    parameter int NREG = NREG_D,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_hold,
    input  logic              dbg_iwe,
    input  logic              dbg_dwe,
    input  logic [ALEN-1:0]   dbg_addr,
    input  logic [IWORD-1:0]  dbg_idata,
    input  logic [XLEN-1:0]   dbg_ddata,
    input  logic [ALEN-1:0]   obs_addr,
    output logic [ALEN-1:0]   obs_pc,
    output logic [NREG*XLEN-1:0] obs_regs,
    output logic [XLEN-1:0]   obs_mem_data
);
    logic [ALEN-1:0] pc, pc_next;
    logic [IWORD-1:0] iword;
    insn_t ins;
    logic commit;
    logic [XLEN-1:0] src_a, src_b, sum, load_val, wb_data;
    logic [RIDX-1:0] rb_sel;
    logic [ALEN-1:0] eaddr;
    logic rf_we, dm_we;
    logic [ALEN-1:0] dm_wa;
    logic [XLEN-1:0] dm_wd;

    assign ins    = insn_t'(iword);
    assign commit = rst_n && !dbg_hold;

    tcpu_imem #(.IW(IWORD), .A(ALEN)) u_imem (
        .clk(clk), .we(dbg_hold && dbg_iwe), .wa(dbg_addr), .wd(dbg_idata),
        .ra(pc), .rd(iword)
    );

    // Second read port follows field C for add, field A otherwise.
    assign rb_sel = (ins.op == OP_ADD) ? ins.fc : ins.fa;

    tcpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(ins.fa), .wd(wb_data),
        .ra_a(ins.fb), .rd_a(src_a), .ra_b(rb_sel), .rd_b(src_b),
        .regs_flat(obs_regs)
    );

    // Execute: adder, effective address and write-back select.
    always_comb begin
        sum     = src_a + src_b;
        eaddr   = src_a[ALEN-1:0] + ins.imm;
        wb_data = (ins.op == OP_LW) ? load_val : sum;
        rf_we   = commit && (ins.op == OP_ADD || ins.op == OP_LW);
    end

    // Data-memory write port: debug preload while held, store otherwise.
    always_comb begin
        dm_we = dbg_hold ? dbg_dwe : (commit && ins.op == OP_SW);
        dm_wa = dbg_hold ? dbg_addr : eaddr;
        dm_wd = dbg_hold ? dbg_ddata : src_b;
    end

    tcpu_dmem #(.W(XLEN), .A(ALEN)) u_dm (
        .clk(clk), .we(dm_we), .wa(dm_wa), .wd(dm_wd),
        .ra_x(eaddr), .rd_x(load_val), .ra_o(obs_addr), .rd_o(obs_mem_data)
    );

    // Next-PC selection: jump, taken branch, or sequential step.
    always_comb begin
        pc_next = pc + 1'b1;
        if (ins.op == OP_JMP)
            pc_next = ins.imm;
        else if (ins.op == OP_BEQ && src_a == src_b)
            pc_next = pc + 1'b1 + ins.imm;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (commit) pc <= pc_next;
    end

    assign obs_pc = pc;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && obs_regs == '0));
    assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hold |=> ($stable(pc) && $stable(obs_regs)));
    assert_store_keeps_regs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ins.op == OP_SW) |=> $stable(obs_regs));
    assert_branch_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ins.op == OP_BEQ && obs_regs[ins.fa*XLEN +: XLEN] != obs_regs[ins.fb*XLEN +: XLEN])
        |=> pc == $past(pc) + 1'b1);
    assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ins.op == OP_JMP) |=> pc == $past(iword[ALEN-1:0]));
    assert_spare_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ins.op > OP_JMP) |=> (pc == $past(pc) + 1'b1 && $stable(obs_regs)));
endmodule

// File: tb/tiny_cpu_tb.sv
`timescale 1ns/1ps
module tiny_cpu_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_hold = 1'b1, dbg_iwe = 1'b0, dbg_dwe = 1'b0;
    logic [5:0] dbg_addr = '0, obs_addr = '0;
    logic [15:0] dbg_idata = '0;
    logic [7:0] dbg_ddata = '0;
    logic [5:0] obs_pc;
    logic [31:0] obs_regs;
    logic [7:0] obs_mem_data;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tiny_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_hold(dbg_hold), .dbg_iwe(dbg_iwe),
        .dbg_dwe(dbg_dwe), .dbg_addr(dbg_addr), .dbg_idata(dbg_idata),
        .dbg_ddata(dbg_ddata), .obs_addr(obs_addr), .obs_pc(obs_pc),
        .obs_regs(obs_regs), .obs_mem_data(obs_mem_data)
    );

    // Encoding per R3: {op[2:0], A[1:0], B[1:0], C[1:0], spare, imm[5:0]}.
    function automatic logic [15:0] enc(input logic [2:0] op, input logic [1:0] a,
                                        input logic [1:0] b, input logic [1:0] c,
                                        input logic sp, input logic [5:0] imm);
        return {op, a, b, c, sp, imm};
    endfunction

    function automatic logic [15:0] prog(input int a);
        case (a)
            0:  return enc(3'd1, 2'd1, 2'd0, 2'd0, 1'b0, 6'd0);   // lw r1,0(r0)
            1:  return enc(3'd1, 2'd2, 2'd0, 2'd0, 1'b0, 6'd1);   // lw r2,1(r0)
            2:  return enc(3'd0, 2'd3, 2'd1, 2'd2, 1'b1, 6'd0);   // add r3,r1,r2, spare set
            3:  return enc(3'd1, 2'd1, 2'd0, 2'd0, 1'b0, 6'd2);   // lw r1,2(r0)
            4:  return enc(3'd0, 2'd3, 2'd3, 2'd1, 1'b0, 6'd0);   // add r3,r3,r1
            5:  return enc(3'd2, 2'd3, 2'd0, 2'd0, 1'b0, 6'd4);   // sw r3,4(r0)
            6:  return enc(3'd1, 2'd2, 2'd0, 2'd0, 1'b0, 6'd4);   // lw r2,4(r0)
            7:  return enc(3'd3, 2'd2, 2'd3, 2'd0, 1'b0, 6'd2);   // beq r2,r3,+2
            8, 9: return enc(3'd0, 2'd0, 2'd1, 2'd1, 1'b0, 6'd0); // skipped
            10: return enc(3'd3, 2'd1, 2'd2, 2'd0, 1'b0, 6'd5);   // beq r1,r2,+5
            11: return enc(3'd1, 2'd0, 2'd0, 2'd0, 1'b0, 6'h3F);  // lw r0,-1(r0)
            12: return enc(3'd5, 2'd1, 2'd1, 2'd1, 1'b0, 6'd3);   // spare opcode
            13: return enc(3'd0, 2'd1, 2'd1, 2'd1, 1'b0, 6'd0);   // add r1,r1,r1
            14: return enc(3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 6'd60);  // j 60
            60: return enc(3'd3, 2'd0, 2'd0, 2'd0, 1'b0, 6'd23);  // beq r0,r0,+23 -> 20
            20: return enc(3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 6'd20);  // j 20
            default: return 16'hA000;                             // opcode 5
        endcase
    endfunction

    function automatic logic [7:0] dinit(input int a);
        case (a)
            0: return 8'd5;
            1: return 8'd7;
            2: return 8'd250;
            63: return 8'h33;
            default: return 8'd0;
        endcase
    endfunction

    // Expected state after each commit: {pc, r3, r2, r1, r0}.
    localparam logic [37:0] VEC [0:14] = '{
        {6'd1,  8'd0,  8'd0, 8'd5,   8'h00},  // R5 lw
        {6'd2,  8'd0,  8'd7, 8'd5,   8'h00},  // R5
        {6'd3,  8'd12, 8'd7, 8'd5,   8'h00},  // R4 add, R3 spare bit ignored
        {6'd4,  8'd12, 8'd7, 8'd250, 8'h00},  // R5
        {6'd5,  8'd6,  8'd7, 8'd250, 8'h00},  // R4 wrap 262 -> 6
        {6'd6,  8'd6,  8'd7, 8'd250, 8'h00},  // R6 sw keeps regs
        {6'd7,  8'd6,  8'd6, 8'd250, 8'h00},  // R6 stored byte read back
        {6'd10, 8'd6,  8'd6, 8'd250, 8'h00},  // R7 taken
        {6'd11, 8'd6,  8'd6, 8'd250, 8'h00},  // R7 not taken
        {6'd12, 8'd6,  8'd6, 8'd250, 8'h33},  // R5 address wraps to 63
        {6'd13, 8'd6,  8'd6, 8'd250, 8'h33},  // R9 spare opcode
        {6'd14, 8'd6,  8'd6, 8'd244, 8'h33},  // R4 same-register read/write
        {6'd60, 8'd6,  8'd6, 8'd244, 8'h33},  // R8 jump
        {6'd20, 8'd6,  8'd6, 8'd244, 8'h33},  // R7 taken target wraps
        {6'd20, 8'd6,  8'd6, 8'd244, 8'h33}   // R8 self jump
    };
    localparam int VREQ [0:14] = '{5, 5, 4, 5, 4, 6, 6, 7, 7, 5, 9, 4, 8, 7, 8};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Preload both memories while held (R2).
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            dbg_iwe = 1'b1; dbg_dwe = 1'b1; dbg_addr = 6'(a);
            dbg_idata = prog(a); dbg_ddata = dinit(a);
        end
        @(negedge clk);
        dbg_iwe = 1'b0; dbg_dwe = 1'b0;
        check("R1 reset pc", 64'(obs_pc), 64'd0);
        check("R1 reset regs", 64'(obs_regs), 64'd0);
        obs_addr = 6'd63;
        #0.1 check("R10 preload readout", 64'(obs_mem_data), 64'h33);

        // Vector walk: one commit per clock.
        dbg_hold = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(posedge clk); @(negedge clk);
            check($sformatf("R%0d vec%0d pc", VREQ[i], i), 64'(obs_pc), 64'(VEC[i][37:32]));
            check($sformatf("R%0d vec%0d regs", VREQ[i], i), 64'(obs_regs), 64'(VEC[i][31:0]));
        end

        // Stored byte visible; source bytes untouched.
        obs_addr = 6'd4;  #0.1 check("R6 mem[4]", 64'(obs_mem_data), 64'd6);
        obs_addr = 6'd63; #0.1 check("R5 mem[63] kept", 64'(obs_mem_data), 64'h33);

        // Hold freezes state and enables debug writes.
        dbg_hold = 1'b1; dbg_dwe = 1'b1; dbg_addr = 6'd10; dbg_ddata = 8'hAA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        dbg_dwe = 1'b0;
        check("R2 hold pc", 64'(obs_pc), 64'd20);
        check("R2 hold regs", 64'(obs_regs), 64'(VEC[14][31:0]));
        obs_addr = 6'd10; #0.1 check("R2 debug write", 64'(obs_mem_data), 64'hAA);

        // Reset while running clears PC/regs, keeps memory.
        dbg_hold = 1'b0; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 run reset pc", 64'(obs_pc), 64'd0);
        check("R1 run reset regs", 64'(obs_regs), 64'd0);
        obs_addr = 6'd4; #0.1 check("R1 memory kept", 64'(obs_mem_data), 64'd6);

        // Debug write while not held is ignored; lw r1,0(r0) commits.
        rst_n = 1'b1; dbg_dwe = 1'b1; dbg_addr = 6'd40; dbg_ddata = 8'h5A;
        @(posedge clk); @(negedge clk);
        dbg_dwe = 1'b0; dbg_hold = 1'b1;
        obs_addr = 6'd40; #0.1 check("R2 write ignored unheld", 64'(obs_mem_data), 64'd0);
        check("R5 restart lw", 64'(obs_regs), 64'h0000_0500);
        finish_run();
    end
endmodule